// File: doc/BRIEF.md
# Program Counter Control-Transfer Unit

This block owns the 15-bit program counter of a small 8-bit core with separate program and data spaces. Each cycle it either holds the counter or applies one control-transfer command from the decoder. A command is a transfer kind plus the instruction fields that kind needs: a long target, a page-relative target, a signed relative offset, the accumulator, or the instruction length. The address-forming modes keep different parts of the counter. A long transfer replaces all 15 bits. An in-page transfer keeps the top 3 bits. A relative branch is a full 15-bit sum. Accumulator-indexed jumps and table reads keep the upper 7 bits.

The unit also drives the program-memory address and returns the byte read from it. Program memory answers one cycle after the address. A read at or beyond the implemented size (parameter `PROG_SIZE`) returns 0x00, which the core executes as a trap. A table transfer takes two cycles. In the first cycle the table address is sent to memory. In the second cycle the returned byte either replaces the low counter byte or is handed back as a load result.

The command input is valid/ready. The decoder holds `cmd_valid` and every command field stable until `cmd_ready` is seen high at a clock edge. While `cmd_valid` is low the counter holds. `cmd_ready` drops for the first cycle of a table command. It also stays low while a call finds the return-stack push port not ready, and while a return finds no popped value valid. The push and pop ports are valid/ready themselves: a push completes when `stk_push_valid` and `stk_push_ready` are both high, and a pop completes when `stk_pop_valid` and `stk_pop_ready` are both high.

Top module: `pc_xfer_unit`

## Requirements
- R1: After reset the counter `pc` is 0x0000 and `fetch_addr` is 0x0000.
- R2: Kind 0 (sequential) advances `pc` by `cmd_len`, which is 1 to 3, modulo 2^15.
- R3: Kind 1 (long jump) and kind 7 (long call) load all 15 bits of `pc` from `cmd_imm`.
- R4: Kind 2 (page jump) and kind 8 (page call) set `pc` to {pc[14:12], cmd_imm[11:0]}, so the top 3 bits are unchanged.
- R5: Kind 3 (relative) sets `pc` to pc plus the sign-extended 6-bit `cmd_rel`, modulo 2^15, for any offset from -32 to +31 except 0, across any page boundary.
- R6: Kind 4 (indexed jump) sets `pc` to {pc[14:8], acc}.
- R7: Kind 5 (table jump) takes two cycles. In the first, `fetch_addr` is {pc[14:8], acc} and `cmd_ready` is low. In the second, `pc` becomes {pc[14:8], byte}, where byte is the data returned for that address.
- R8: Kind 6 (table load) reads the same address in the same two cycles. In the completing cycle `tbl_valid` is high and `tbl_data` carries the byte, and `pc` advances by `cmd_len`.
- R9: Kinds 7 and 8 present pc + `cmd_len` on `stk_push_data` with `stk_push_valid` high. The call completes only when `stk_push_ready` is high; until then `cmd_ready` is low and `pc` holds.
- R10: Kind 9 (return) raises `stk_pop_ready` and waits with `cmd_ready` low and `pc` held until `stk_pop_valid` is high. It then loads `pc` from `stk_pop_data`.
- R11: `fetch_data` one cycle after address a equals `mem_rdata` when a < `PROG_SIZE`, and 0x00 when a >= `PROG_SIZE`.
- R12: While `cmd_valid` is low, `pc` does not change whatever the other command inputs carry. Kind codes 10 to 15 act as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted at this edge |
| cmd_kind | input | 4 | Transfer kind code (0 to 9) |
| cmd_len | input | 2 | Length of the current instruction in bytes |
| cmd_imm | input | 15 | Long target, or page target in the low 12 bits |
| cmd_rel | input | 6 | Signed relative offset |
| acc | input | 8 | Accumulator value |
| stk_push_valid | output | 1 | Return address offered to the stack |
| stk_push_ready | input | 1 | Stack accepts the push |
| stk_push_data | output | 15 | Return address |
| stk_pop_ready | output | 1 | Unit takes a popped address |
| stk_pop_valid | input | 1 | Popped address available |
| stk_pop_data | input | 15 | Popped address |
| fetch_addr | output | 15 | Program-memory address |
| mem_rdata | input | 8 | Memory data for the previous cycle's address |
| fetch_data | output | 8 | Fetched byte, with the trap substitution applied |
| tbl_valid | output | 1 | Table-load result present |
| tbl_data | output | 8 | Table-load byte |
| pc | output | 15 | Current program counter |

## Verification
The bound checker checks the following on every cycle:
- the target rule of each single-cycle kind: full load, top-3-bit page hold, 15-bit relative sum and indexed low byte;
- the return address that a call offers;
- that the counter holds while no command is valid;
- the trap substitution for an out-of-range address;
- the stall in the first cycle of a table command.

Only the bench scenarios show several behaviours:
- two-cycle table transfers, where the byte read from memory decides the target, including a table address past the end of memory;
- stalls against a stack port that is not ready or has no popped value;
- wrap-around at the top of the 15-bit space;
- the exact boundary at `PROG_SIZE`.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  typedef enum logic [3:0] {
    XK_SEQ   = 4'd0,
    XK_JLONG = 4'd1,
    XK_JPAGE = 4'd2,
    XK_JREL  = 4'd3,
    XK_JIDX  = 4'd4,
    XK_JTAB  = 4'd5,
    XK_LTAB  = 4'd6,
    XK_CLONG = 4'd7,
    XK_CPAGE = 4'd8,
    XK_RET   = 4'd9
  } xfer_kind_e;

  localparam logic [7:0] TRAP_OPCODE = 8'h00;

  function automatic logic kind_is_table(input logic [3:0] k);
    return (k == XK_JTAB) || (k == XK_LTAB);
  endfunction

  function automatic logic kind_is_call(input logic [3:0] k);
    return (k == XK_CLONG) || (k == XK_CPAGE);
  endfunction
endpackage

// File: rtl/pcx_target.sv
module pcx_target #(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 8,
  parameter int REL_W  = 6,
  parameter int LEN_W  = 2
) (
  input  logic [3:0]       kind,
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [LEN_W-1:0] len,
  input  logic [PC_W-1:0]  imm,
  input  logic [REL_W-1:0] rel,
  input  logic [IDX_W-1:0] acc,
  input  logic [IDX_W-1:0] tab_byte,
  input  logic [PC_W-1:0]  pop_addr,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  link_addr,
  output logic [PC_W-1:0]  tab_addr
);
  import pcx_pkg::*;

  localparam int HI_PAGE = PC_W - PAGE_W;
  localparam int HI_IDX  = PC_W - IDX_W;
  localparam int EXT_W   = PC_W - REL_W;

  logic [PC_W-1:0] seq_tgt, rel_tgt, page_tgt, idx_tgt, tabj_tgt, rel_ext;

  always_comb begin
    rel_ext   = {{EXT_W{rel[REL_W-1]}}, rel};
    seq_tgt   = pc_cur + PC_W'(len);
    rel_tgt   = pc_cur + rel_ext;
    page_tgt  = {pc_cur[PC_W-1 -: HI_PAGE], imm[PAGE_W-1:0]};
    idx_tgt   = {pc_cur[PC_W-1 -: HI_IDX], acc};
    tabj_tgt  = {pc_cur[PC_W-1 -: HI_IDX], tab_byte};
    tab_addr  = idx_tgt;
    link_addr = seq_tgt;
  end

  always_comb begin
    case (kind)
      XK_JLONG, XK_CLONG: next_pc = imm;
      XK_JPAGE, XK_CPAGE: next_pc = page_tgt;
      XK_JREL:            next_pc = rel_tgt;
      XK_JIDX:            next_pc = idx_tgt;
      XK_JTAB:            next_pc = tabj_tgt;
      XK_RET:             next_pc = pop_addr;
      default:            next_pc = seq_tgt;
    endcase
  end
endmodule

// File: rtl/pcx_seq.sv
module pcx_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [3:0] kind,
  input  logic       push_ready,
  input  logic       pop_valid,
  output logic       cmd_ready,
  output logic       fire,
  output logic       tab_issue,
  output logic       push_valid,
  output logic       pop_ready
);
  import pcx_pkg::*;

  logic tab_phase_q;
  logic is_tab, is_call, is_ret;

  always_comb begin
    is_tab  = kind_is_table(kind);
    is_call = kind_is_call(kind);
    is_ret  = (kind == XK_RET);
    if (is_tab)       cmd_ready = tab_phase_q;
    else if (is_call) cmd_ready = push_ready;
    else if (is_ret)  cmd_ready = pop_valid;
    else              cmd_ready = 1'b1;
    fire       = cmd_valid && cmd_ready;
    tab_issue  = cmd_valid && is_tab && !tab_phase_q;
    push_valid = cmd_valid && is_call;
    pop_ready  = cmd_valid && is_ret;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         tab_phase_q <= 1'b0;
    else if (tab_issue) tab_phase_q <= 1'b1;
    else if (fire)      tab_phase_q <= 1'b0;
  end
endmodule

// File: rtl/pcx_guard.sv
module pcx_guard #(
  parameter int PC_W      = 15,
  parameter int PROG_SIZE = 20480
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] addr,
  input  logic [7:0]      mem_rdata,
  output logic [7:0]      fetch_data
);
  import pcx_pkg::*;

  logic oor, oor_q;

  generate
    if (PROG_SIZE >= (1 << PC_W)) begin : g_full
      assign oor = 1'b0;
    end else begin : g_partial
      localparam logic [PC_W:0] LIMIT = (PC_W+1)'(PROG_SIZE);
      assign oor = ({1'b0, addr} >= LIMIT);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) oor_q <= 1'b0;
    else        oor_q <= oor;
  end

  assign fetch_data = oor_q ? TRAP_OPCODE : mem_rdata;
endmodule

// File: rtl/pc_xfer_unit.sv
module pc_xfer_unit #(
  parameter int PC_W      = 15,
  parameter int PAGE_W    = 12,
  parameter int IDX_W     = 8,
  parameter int REL_W     = 6,
  parameter int LEN_W     = 2,
  parameter int PROG_SIZE = 20480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_kind,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [PC_W-1:0]  cmd_imm,
  input  logic [REL_W-1:0] cmd_rel,
  input  logic [IDX_W-1:0] acc,
  output logic             stk_push_valid,
  input  logic             stk_push_ready,
  output logic [PC_W-1:0]  stk_push_data,
  output logic             stk_pop_ready,
  input  logic             stk_pop_valid,
  input  logic [PC_W-1:0]  stk_pop_data,
  output logic [PC_W-1:0]  fetch_addr,
  input  logic [7:0]       mem_rdata,
  output logic [7:0]       fetch_data,
  output logic             tbl_valid,
  output logic [7:0]       tbl_data,
  output logic [PC_W-1:0]  pc
);
  import pcx_pkg::*;

  logic            fire, tab_issue;
  logic [PC_W-1:0] pc_q, next_pc, link_addr, tab_addr;

  pcx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .kind       (cmd_kind),
    .push_ready (stk_push_ready),
    .pop_valid  (stk_pop_valid),
    .cmd_ready  (cmd_ready),
    .fire       (fire),
    .tab_issue  (tab_issue),
    .push_valid (stk_push_valid),
    .pop_ready  (stk_pop_ready)
  );

  pcx_target #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .REL_W(REL_W), .LEN_W(LEN_W)
  ) u_target (
    .kind      (cmd_kind),
    .pc_cur    (pc_q),
    .len       (cmd_len),
    .imm       (cmd_imm),
    .rel       (cmd_rel),
    .acc       (acc),
    .tab_byte  (fetch_data[IDX_W-1:0]),
    .pop_addr  (stk_pop_data),
    .next_pc   (next_pc),
    .link_addr (link_addr),
    .tab_addr  (tab_addr)
  );

  pcx_guard #(.PC_W(PC_W), .PROG_SIZE(PROG_SIZE)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (fetch_addr),
    .mem_rdata  (mem_rdata),
    .fetch_data (fetch_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= '0;
    else if (fire) pc_q <= next_pc;
  end

  assign fetch_addr    = tab_issue ? tab_addr : pc_q;
  assign stk_push_data = link_addr;
  assign tbl_valid     = fire && (cmd_kind == XK_LTAB);
  assign tbl_data      = fetch_data;
  assign pc            = pc_q;
endmodule

// File: rtl/pcx_chk.sv
module pcx_chk #(
  parameter int PC_W      = 15,
  parameter int PROG_SIZE = 20480
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [3:0]      cmd_kind,
  input logic [1:0]      cmd_len,
  input logic [PC_W-1:0] cmd_imm,
  input logic [5:0]      cmd_rel,
  input logic [7:0]      acc,
  input logic            stk_push_valid,
  input logic            stk_push_ready,
  input logic [PC_W-1:0] stk_push_data,
  input logic [PC_W-1:0] fetch_addr,
  input logic [7:0]      fetch_data,
  input logic [PC_W-1:0] pc
);
  import pcx_pkg::*;

  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(PROG_SIZE);
  logic acc_ok;
  assign acc_ok = cmd_valid && cmd_ready;

  AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (cmd_kind == XK_JLONG || cmd_kind == XK_CLONG) |=> pc == $past(cmd_imm)); // R3
  AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (cmd_kind == XK_JPAGE || cmd_kind == XK_CPAGE)
    |=> pc[PC_W-1:12] == $past(pc[PC_W-1:12]) && pc[11:0] == $past(cmd_imm[11:0])); // R4
  AST_REL_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && cmd_kind == XK_JREL
    |=> pc == PC_W'($past(pc) + {{(PC_W-6){$past(cmd_rel[5])}}, $past(cmd_rel)})); // R5
  AST_IDX_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && cmd_kind == XK_JIDX
    |=> pc == {$past(pc[PC_W-1:8]), $past(acc)}); // R6
  AST_TAB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && kind_is_table(cmd_kind) && !cmd_ready
    |-> fetch_addr == {pc[PC_W-1:8], acc}); // R7
  AST_PUSH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push_valid |-> stk_push_data == PC_W'(pc + PC_W'(cmd_len))); // R9
  AST_CALL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    stk_push_valid && !stk_push_ready |=> $stable(pc)); // R9
  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fetch_addr} >= LIMIT) |=> fetch_data == 8'h00); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(pc)); // R12
endmodule

bind pc_xfer_unit pcx_chk #(.PC_W(PC_W), .PROG_SIZE(PROG_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_len(cmd_len), .cmd_imm(cmd_imm), .cmd_rel(cmd_rel),
  .acc(acc), .stk_push_valid(stk_push_valid), .stk_push_ready(stk_push_ready),
  .stk_push_data(stk_push_data), .fetch_addr(fetch_addr),
  .fetch_data(fetch_data), .pc(pc)
);

// File: tb/pc_xfer_unit_tb.sv
module pc_xfer_unit_tb;
  localparam int SIZE = 20480;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_kind = '0;
  logic [1:0]  cmd_len = 2'd1;
  logic [14:0] cmd_imm = '0;
  logic [5:0]  cmd_rel = '0;
  logic [7:0]  acc = '0;
  logic        stk_push_valid, stk_pop_ready, tbl_valid;
  logic        stk_push_ready = 1'b1;
  logic        stk_pop_valid = 1'b0;
  logic [14:0] stk_push_data, fetch_addr, pc;
  logic [14:0] stk_pop_data = '0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  fetch_data, tbl_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [14:0] exp_pc;
  logic        got_tbl;
  logic [7:0]  got_tbl_data;

  always #2.5 clk = ~clk;

  pc_xfer_unit #(.PROG_SIZE(SIZE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_len(cmd_len), .cmd_imm(cmd_imm), .cmd_rel(cmd_rel),
    .acc(acc), .stk_push_valid(stk_push_valid), .stk_push_ready(stk_push_ready),
    .stk_push_data(stk_push_data), .stk_pop_ready(stk_pop_ready),
    .stk_pop_valid(stk_pop_valid), .stk_pop_data(stk_pop_data),
    .fetch_addr(fetch_addr), .mem_rdata(mem_rdata), .fetch_data(fetch_data),
    .tbl_valid(tbl_valid), .tbl_data(tbl_data), .pc(pc)
  );

  function automatic logic [7:0] mem_byte(input logic [14:0] a);
    return 8'(a * 37 + (a >> 8) + 5);
  endfunction

  function automatic logic [7:0] exp_fetch(input logic [14:0] a);
    return (int'(a) >= SIZE) ? 8'h00 : mem_byte(a);
  endfunction

  always @(posedge clk) mem_rdata <= mem_byte(fetch_addr);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] k, input logic [1:0] l, input logic [14:0] im,
                       input logic [5:0] r, input logic [7:0] a);
    cmd_kind = k; cmd_len = l; cmd_imm = im; cmd_rel = r; acc = a;
    cmd_valid = 1'b1;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
    end
    got_tbl = tbl_valid;
    got_tbl_data = tbl_data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic jump(input logic [14:0] a);
    issue(4'd1, 2'd3, a, 6'd0, 8'd0);
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(pc == 15'h0, "R1 reset pc", pc, 0);
    chk(fetch_addr == 15'h0, "R1 reset fetch_addr", fetch_addr, 0);

    // R2 sequential and wrap
    for (int l = 1; l <= 3; l++) begin
      exp_pc = pc + 15'(l);
      issue(4'd0, 2'(l), 15'h7777, 6'd5, 8'h33);
      chk(pc == exp_pc, "R2 seq", pc, exp_pc);
    end
    jump(15'h7FFE);
    issue(4'd0, 2'd3, 15'h0, 6'd0, 8'd0);
    chk(pc == 15'h0001, "R2 wrap", pc, 1);
    issue(4'd12, 2'd2, 15'h1234, 6'd0, 8'd0);
    chk(pc == 15'h0003, "R12 unused kind acts sequential", pc, 3);

    // R3 long jump and call
    for (int i = 0; i < 16; i++) begin
      exp_pc = (i == 15) ? 15'h7FFF : 15'(1 << i);
      issue((i % 2 == 0) ? 4'd1 : 4'd7, 2'd3, exp_pc, 6'd0, 8'd0);
      chk(pc == exp_pc, "R3 long", pc, exp_pc);
    end

    // R4 page jump and call
    for (int b = 0; b < 3; b++) begin
      for (int m = 0; m < 3; m++) begin
        logic [14:0] base, im;
        base = (b == 0) ? 15'h0000 : (b == 1) ? 15'h3ABC : 15'h7FFF;
        im   = (m == 0) ? 15'h7000 : (m == 1) ? 15'h0FFF : 15'h55A5;
        jump(base);
        issue((m == 1) ? 4'd8 : 4'd2, 2'd2, im, 6'd0, 8'd0);
        exp_pc = {base[14:12], im[11:0]};
        chk(pc == exp_pc, "R4 page", pc, exp_pc);
      end
    end

    // R5 relative sweep, all 63 offsets, four bases
    for (int b = 0; b < 4; b++) begin
      for (int o = -32; o <= 31; o++) begin
        logic [14:0] base;
        if (o == 0) continue;
        base = (b == 0) ? 15'h1000 : (b == 1) ? 15'h0010 : (b == 2) ? 15'h7FF0 : 15'h0FFF;
        jump(base);
        issue(4'd3, 2'd1, 15'h0, 6'(o), 8'd0);
        exp_pc = 15'(int'(base) + o);
        chk(pc == exp_pc, "R5 rel", pc, exp_pc);
      end
    end

    // R6 indexed jump, full accumulator sweep
    for (int a = 0; a < 256; a++) begin
      jump(15'h2345);
      issue(4'd4, 2'd1, 15'h0, 6'd0, 8'(a));
      exp_pc = {7'h23, 8'(a)};
      chk(pc == exp_pc, "R6 idx", pc, exp_pc);
    end

    // R7 table jump incl. table address past memory end
    for (int t = 0; t < 6; t++) begin
      logic [14:0] base, taddr;
      logic [7:0] a;
      base = (t < 5) ? 15'(16'h1234 + t * 16'h0100) : 15'h50F0;
      a = 8'(t * 51 + 16);
      taddr = {base[14:8], a};
      jump(base);
      cmd_kind = 4'd5; acc = a; cmd_len = 2'd1; cmd_valid = 1'b1;
      #1;
      chk(cmd_ready == 1'b0, "R7 first cycle stall", cmd_ready, 0);
      chk(fetch_addr == taddr, "R7 table addr", fetch_addr, taddr);
      issue(4'd5, 2'd1, 15'h0, 6'd0, a);
      exp_pc = {base[14:8], exp_fetch(taddr)};
      chk(pc == exp_pc, "R7 table jump", pc, exp_pc);
    end

    // R8 table load
    for (int t = 0; t < 4; t++) begin
      logic [14:0] base, taddr;
      logic [7:0] a;
      base = (t == 3) ? 15'h4FF0 : 15'(16'h0200 + t * 16'h0777);
      a = (t == 3) ? 8'hFF : 8'(t * 90 + 7);
      taddr = {base[14:8], a};
      jump(base);
      issue(4'd6, 2'd2, 15'h0, 6'd0, a);
      chk(got_tbl == 1'b1, "R8 tbl_valid", got_tbl, 1);
      chk(got_tbl_data == exp_fetch(taddr), "R8 tbl_data", got_tbl_data, exp_fetch(taddr));
      chk(pc == 15'(base + 2), "R8 pc advance", pc, base + 2);
    end

    // R9 call push with back-pressure
    jump(15'h0ABC);
    stk_push_ready = 1'b0;
    cmd_kind = 4'd7; cmd_len = 2'd3; cmd_imm = 15'h6000; cmd_valid = 1'b1;
    repeat (3) begin
      #1;
      chk(cmd_ready == 1'b0 && stk_push_valid == 1'b1, "R9 stall", cmd_ready, 0);
      chk(stk_push_data == 15'h0ABF, "R9 link", stk_push_data, 15'h0ABF);
      @(negedge clk);
      chk(pc == 15'h0ABC, "R9 hold", pc, 15'h0ABC);
    end
    stk_push_ready = 1'b1;
    issue(4'd7, 2'd3, 15'h6000, 6'd0, 8'd0);
    chk(pc == 15'h6000, "R9 call target", pc, 15'h6000);

    // R10 return waits for pop
    stk_pop_valid = 1'b0;
    stk_pop_data = 15'h1357;
    cmd_kind = 4'd9; cmd_valid = 1'b1;
    repeat (2) begin
      #1;
      chk(cmd_ready == 1'b0 && stk_pop_ready == 1'b1, "R10 wait", cmd_ready, 0);
      @(negedge clk);
      chk(pc == 15'h6000, "R10 hold", pc, 15'h6000);
    end
    stk_pop_valid = 1'b1;
    issue(4'd9, 2'd1, 15'h0, 6'd0, 8'd0);
    stk_pop_valid = 1'b0;
    chk(pc == 15'h1357, "R10 return", pc, 15'h1357);

    // R11 fetch data and trap at the size boundary
    for (int d = -3; d <= 4; d++) begin
      logic [14:0] a;
      a = (d == 4) ? 15'h7FFF : 15'(SIZE + d);
      jump(a);
      @(negedge clk);
      chk(fetch_data == exp_fetch(a), "R11 fetch", fetch_data, exp_fetch(a));
    end
    jump(15'h0000);
    @(negedge clk);
    chk(fetch_data == mem_byte(15'h0), "R11 fetch low", fetch_data, mem_byte(15'h0));

    // R12 idle holds whatever the fields carry
    jump(15'h2222);
    cmd_kind = 4'd1; cmd_imm = 15'h5555; cmd_rel = 6'h20; acc = 8'hAA;
    repeat (5) @(negedge clk);
    chk(pc == 15'h2222, "R12 idle hold", pc, 15'h2222);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule